// File: doc/BRIEF.md
# UART FIFO Control and Receive DMA Request

This block holds the FIFO control register of a UART. Software writes it over a simple register bus. The register enables the receive and transmit FIFOs, picks DMA mode and chooses a receive trigger threshold. The block turns register activity into single-cycle flush strobes for both FIFOs. It also raises a receive DMA request from the receive FIFO fill level and a character-timeout flag that come from the surrounding UART.

The FIFOs, the shifters and the DMA engine sit outside this block. They meet it only through the fill level, timeout, flush and request pins. All pins are plain control and status lines with no handshake. A write is taken in the clock cycle where `reg_wr_en` is high, and the bus never stalls.

Top module: `uart_fifo_ctl`

## Requirements
- R1: After reset, the register reads 0x00, both flush outputs are low and `rx_dma_req` is low.
- R2: A write with data bit 0 set stores all fields: enable from bit 0, DMA mode from bit 3 and trigger code from bits 7:6. A read returns these three fields in those positions, and bits 1, 2, 4 and 5 always read 0.
- R3: A write with data bit 0 clear changes only the enable bit. The DMA mode and trigger fields keep their values, and the strobe bits in that write have no effect.
- R4: A write that changes the stored enable bit, from 0 to 1 or from 1 to 0, raises both `rx_flush` and `tx_flush` for exactly the one cycle after the write.
- R5: A write with bit 0 set and bit 1 set pulses `rx_flush` for one cycle. A write with bit 0 set and bit 2 set pulses `tx_flush` for one cycle. Each strobe affects only its own FIFO.
- R6: `rx_dma_req` stays low whenever the stored enable bit is 0 or the stored DMA mode bit is 0.
- R7: With enable and DMA mode set, `rx_dma_req` is high exactly when `rx_level` is at least the threshold. For a 16-entry FIFO, trigger codes 0, 1, 2 and 3 give thresholds of 1, 4, 8 and 14. In general the thresholds are 1, DEPTH/4, DEPTH/2 and DEPTH-2.
- R8: With enable and DMA mode set, a high `rx_timeout` raises `rx_dma_req` at any fill level.
- R9: `rx_dma_req` follows its inputs in the same cycle. It drops as soon as the level falls below the threshold while no timeout is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| rx_level | input | $clog2(DEPTH+1) | Receive FIFO fill level |
| rx_timeout | input | 1 | Character-timeout indication |
| rx_flush | output | 1 | One-cycle receive FIFO flush |
| tx_flush | output | 1 | One-cycle transmit FIFO flush |
| rx_dma_req | output | 1 | Receive DMA request |

## Verification
The assertions assume that `rx_level` never exceeds DEPTH. They also assume that `reg_wr_en` and `reg_wdata` are stable around each rising edge. The bench drives every input at the falling edge. Its level sweep stops at DEPTH, and it writes at most once per two cycles, so each flush pulse can be seen to end before the next write.

// File: rtl/uart_fcr_pkg.sv
package uart_fcr_pkg;
  typedef struct packed {
    logic [1:0] trig;
    logic       dma;
    logic       en;
  } fcr_t;

  function automatic int trig_threshold(input logic [1:0] code, input int depth);
    case (code)
      2'd0:    return 1;
      2'd1:    return depth / 4;
      2'd2:    return depth / 2;
      default: return depth - 2;
    endcase
  endfunction
endpackage

// File: rtl/uart_fcr_reg.sv
module uart_fcr_reg
  import uart_fcr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wdata,
  output fcr_t       fcr,
  output logic [7:0] rdata
);
  fcr_t fcr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fcr_q <= '0;
    end else if (wr_en) begin
      fcr_q.en <= wdata[0];
      if (wdata[0]) begin
        fcr_q.dma  <= wdata[3];
        fcr_q.trig <= wdata[7:6];
      end
    end
  end

  assign fcr   = fcr_q;
  assign rdata = {fcr_q.trig, 2'b00, fcr_q.dma, 2'b00, fcr_q.en};
endmodule

// File: rtl/uart_fcr_flush.sv
module uart_fcr_flush (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wdata,
  input  logic       en_q,
  output logic       rx_flush,
  output logic       tx_flush
);
  logic toggle, rx_d, tx_d;

  always_comb begin
    toggle = wr_en && (wdata[0] != en_q);
    rx_d   = toggle || (wr_en && wdata[0] && wdata[1]);
    tx_d   = toggle || (wr_en && wdata[0] && wdata[2]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_flush <= 1'b0;
      tx_flush <= 1'b0;
    end else begin
      rx_flush <= rx_d;
      tx_flush <= tx_d;
    end
  end
endmodule

// File: rtl/uart_rx_dma_req.sv
module uart_rx_dma_req
  import uart_fcr_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  fcr_t             fcr,
  input  logic [LVL_W-1:0] rx_level,
  input  logic             rx_timeout,
  output logic             req
);
  logic [LVL_W-1:0] thr;

  always_comb begin
    thr = LVL_W'(trig_threshold(fcr.trig, DEPTH));
    req = fcr.en && fcr.dma && ((rx_level >= thr) || rx_timeout);
  end
endmodule

// File: rtl/uart_fifo_ctl.sv
module uart_fifo_ctl
  import uart_fcr_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr_en,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  input  logic [LVL_W-1:0] rx_level,
  input  logic             rx_timeout,
  output logic             rx_flush,
  output logic             tx_flush,
  output logic             rx_dma_req
);
  fcr_t fcr;

  uart_fcr_reg u_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (reg_wr_en),
    .wdata (reg_wdata),
    .fcr   (fcr),
    .rdata (reg_rdata)
  );

  uart_fcr_flush u_flush (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (reg_wr_en),
    .wdata    (reg_wdata),
    .en_q     (fcr.en),
    .rx_flush (rx_flush),
    .tx_flush (tx_flush)
  );

  uart_rx_dma_req #(.DEPTH(DEPTH)) u_req (
    .fcr        (fcr),
    .rx_level   (rx_level),
    .rx_timeout (rx_timeout),
    .req        (rx_dma_req)
  );
endmodule

// File: rtl/uart_fifo_ctl_chk.sv
module uart_fifo_ctl_chk #(
  parameter int DEPTH = 16,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr_en,
  input logic [7:0]       reg_wdata,
  input logic [7:0]       reg_rdata,
  input logic [LVL_W-1:0] rx_level,
  input logic             rx_timeout,
  input logic             rx_flush,
  input logic             tx_flush,
  input logic             rx_dma_req
);
  // R2
  strobe_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[5:4] == 2'b00 && reg_rdata[2:1] == 2'b00);

  // R3
  upper_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && !reg_wdata[0]) |=> reg_rdata[7:1] == $past(reg_rdata[7:1]));

  // R4
  toggle_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && (reg_wdata[0] != reg_rdata[0])) |=> (rx_flush && tx_flush));

  // R5
  no_spurious_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(reg_wr_en) |-> (!rx_flush && !tx_flush));

  // R6
  req_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_rdata[0] && reg_rdata[3]) |-> !rx_dma_req);

  // R8
  timeout_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[0] && reg_rdata[3] && rx_timeout) |-> rx_dma_req);

  // R7
  full_level_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[0] && reg_rdata[3] && rx_level == LVL_W'(DEPTH)) |-> rx_dma_req);
endmodule

bind uart_fifo_ctl uart_fifo_ctl_chk #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/uart_fifo_ctl_tb_top.sv
module uart_fifo_ctl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;
  localparam int LVL_W = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr_en = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [LVL_W-1:0] rx_level = '0;
  logic rx_timeout = 1'b0;
  logic rx_flush, tx_flush, rx_dma_req;

  int n_chk = 0;
  int n_bad = 0;
  logic done = 1'b0;

  logic m_en = 1'b0, m_dma = 1'b0;
  logic [1:0] m_trig = 2'd0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_fifo_ctl #(.DEPTH(DEPTH)) dut_i (.*);

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd();
    return {m_trig, 2'b00, m_dma, 2'b00, m_en};
  endfunction

  task automatic do_write(input logic [7:0] d);
    logic xr, xt;
    xr = (d[0] != m_en) || (d[0] && d[1]);
    xt = (d[0] != m_en) || (d[0] && d[2]);
    m_en = d[0];
    if (d[0]) begin
      m_dma  = d[3];
      m_trig = d[7:6];
    end
    @(negedge clk);
    reg_wr_en = 1'b1;
    reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
    check((d[0] ? "R5" : "R4"), {31'd0, rx_flush}, {31'd0, xr});
    check((d[0] ? "R5" : "R4"), {31'd0, tx_flush}, {31'd0, xt});
    check((d[0] ? "R2" : "R3"), {24'd0, reg_rdata}, {24'd0, exp_rd()});
    @(negedge clk);
    check("R4", {30'd0, rx_flush, tx_flush}, 0);
  endtask

  initial begin
    repeat (CLK_PERIOD * 20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 checks are made with reset still held, then again after its release.
    check("R1", {24'd0, reg_rdata}, 0);
    check("R1", {29'd0, rx_flush, tx_flush, rx_dma_req}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {24'd0, reg_rdata}, 0);

    // R5: strobes while enabled; R3: strobes ignored while disabled
    do_write(8'h01);
    do_write(8'h03);
    do_write(8'h05);
    do_write(8'h07);
    do_write(8'hFE);
    do_write(8'h06);

    for (int en = 0; en < 2; en++) begin
      for (int dm = 0; dm < 2; dm++) begin
        for (int tc = 0; tc < 4; tc++) begin
          do_write({tc[1:0], 2'b11, dm[0], 3'b001});
          if (en == 0) do_write({~tc[1:0], 2'b00, ~dm[0], 3'b000});
          for (int lv = 0; lv <= DEPTH; lv++) begin
            for (int to = 0; to < 2; to++) begin
              int thr;
              logic ex;
              thr = (tc == 0) ? 1 : (tc == 1) ? DEPTH/4 : (tc == 2) ? DEPTH/2 : DEPTH-2;
              ex = (en == 1) && (dm == 1) && ((lv >= thr) || (to == 1));
              rx_level = LVL_W'(lv);
              rx_timeout = to[0];
              #1;
              // R6 R7 R8 R9
              check((en == 0 || dm == 0) ? "R6" : (to == 1 ? "R8" : "R7"),
                    {31'd0, rx_dma_req}, {31'd0, ex});
            end
          end
          // R9: the request drops in the same cycle as the level falls
          rx_timeout = 1'b0;
          rx_level = '0;
          #1;
          check("R9", {31'd0, rx_dma_req}, 0);
        end
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule